// File: doc/BRIEF.md
# Dynamic VID Reference Stepper

This block tracks the 5-bit voltage-identification code that selects the output level of a multi-phase buck controller, and turns it into a reference count in 25 mV units for the downstream DAC. The code is looked at only on a phase-1 cycle-start strobe. A code that differs from the one in force becomes a candidate. It is accepted only if the same value is present at the following strobe.

Once a target is accepted, the reference does not jump. It moves one 25 mV unit toward the target on every second strobe and stops exactly on it. A new code accepted in mid-slew redirects the motion from wherever the reference stands. After reset the reference is loaded directly from the code seen at the first strobe. The all-ones code switches the output off.

Top module: `vid_ref_stepper`

## Requirements
- R1: While reset is asserted, and after reset until the first cycle-start strobe, ref_code is 0 and busy and at_target are both 0.
- R2: At the first strobe after reset, ref_code loads the mapped value of vid in one step, and at_target goes to 1 on the following cycle.
- R3: The mapping gives a target of BASE + vid (BASE = 20 by default) for every code except 5'b11111, which gives a target of 0 (output off).
- R4: Changes of vid between strobes have no effect; only the value present in the clock cycle of a strobe is sampled.
- R5: A code that differs from the accepted code becomes the target only if the same code is sampled again at the next strobe. If a different code is sampled at that strobe, it replaces the candidate, and the target and ref_code do not change.
- R6: After a target is accepted, ref_code changes by exactly one unit on every second strobe, the first step coming at the second strobe after acceptance. ref_code never changes except on the cycle after a strobe.
- R7: ref_code steps up when the target is above it and down when it is below, and it stops exactly at the target.
- R8: A target accepted during a slew takes effect from the present ref_code, without reloading it, and the step cadence restarts.
- R9: After the first strobe, busy is 1 exactly when ref_code differs from the accepted target, at_target is 1 exactly when they are equal, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-cycle pulse at the start of each phase-1 switching cycle |
| vid | input | 5 | Voltage-identification code |
| ref_code | output | REF_W | Present reference in 25 mV units |
| busy | output | 1 | Reference is slewing toward the target |
| at_target | output | 1 | Reference equals the accepted target |

## Verification
The bench wiggles vid between strobes and restores it before the next strobe. A design that sampled vid continuously would start a slew. It sends a code that is replaced at its qualification strobe. A design that accepted on first sight, or that took the second code, would move the target. It redirects an upward slew downward in mid-flight. A design that reloaded the reference, or kept the old step phase, would show a jump or a step in the wrong cycle. It also drives the off code, where a design that did not force zero would stop at BASE + 31.

// File: rtl/vid_ref_stepper.sv
module vid_ref_stepper #(
  parameter int VID_W = 5,
  parameter int REF_W = 7,
  parameter int BASE  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic [VID_W-1:0] vid,
  output logic [REF_W-1:0] ref_code,
  output logic             busy,
  output logic             at_target
);
  localparam logic [VID_W-1:0] OFF_CODE = {VID_W{1'b1}};

  logic             init_q, cand_v_q, ph_q;
  logic [VID_W-1:0] cand_q, acc_q;
  logic [REF_W-1:0] ref_q, tgt_q, vid_tgt;

  always_comb begin
    if (vid == OFF_CODE) vid_tgt = '0;
    else                 vid_tgt = REF_W'(BASE) + REF_W'(vid);
  end

  wire accept = cand_v_q && (vid == cand_q);
  wire moving = (ref_q != tgt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q   <= 1'b0;
      cand_v_q <= 1'b0;
      ph_q     <= 1'b0;
      cand_q   <= '0;
      acc_q    <= '0;
      ref_q    <= '0;
      tgt_q    <= '0;
    end else if (cyc_start) begin
      if (!init_q) begin
        init_q   <= 1'b1;
        ref_q    <= vid_tgt;
        tgt_q    <= vid_tgt;
        acc_q    <= vid;
        cand_v_q <= 1'b0;
        ph_q     <= 1'b0;
      end else if (accept) begin
        tgt_q    <= vid_tgt;
        acc_q    <= vid;
        cand_v_q <= 1'b0;
        ph_q     <= 1'b0;
      end else begin
        cand_q   <= vid;
        cand_v_q <= (vid != acc_q);
        if (moving) begin
          ph_q <= ~ph_q;
          if (ph_q) ref_q <= (tgt_q > ref_q) ? ref_q + 1'b1 : ref_q - 1'b1;
        end
      end
    end
  end

  assign ref_code  = ref_q;
  assign busy      = init_q && moving;
  assign at_target = init_q && !moving;
endmodule

module vid_ref_stepper_chk #(
  parameter int REF_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_start,
  input logic [REF_W-1:0] ref_code,
  input logic             busy,
  input logic             at_target
);
  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && at_target));

  // R6
  strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cyc_start) |-> $stable(ref_code));

  // R6
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy || at_target) |->
      (ref_code == $past(ref_code)) ||
      (ref_code == REF_W'($past(ref_code) + 1'b1)) ||
      (REF_W'(ref_code + 1'b1) == $past(ref_code)));

  // R2
  stays_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy || at_target) |-> (busy || at_target));

  // R1
  idle_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy || at_target) |-> (ref_code == '0));
endmodule

bind vid_ref_stepper vid_ref_stepper_chk #(.REF_W(REF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
  .ref_code(ref_code), .busy(busy), .at_target(at_target)
);

// File: tb/vid_ref_stepper_tb.sv
module vid_ref_stepper_tb;
  localparam int REF_W = 7;
  localparam int BASE  = 20;

  typedef struct packed {
    logic [REF_W-1:0] r;
    logic             b;
    logic             a;
    logic [7:0]       req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, cyc_start = 1'b0;
  logic [4:0] vid = '0;
  logic [REF_W-1:0] ref_code;
  logic busy, at_target;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  exp_t q[$];

  // bench model state, derived from the requirements
  bit m_init = 0, m_cv = 0, m_ph = 0;
  logic [4:0] m_cand = '0, m_acc = '0;
  int m_ref = 0, m_tgt = 0;

  always #2.5 clk = ~clk;

  vid_ref_stepper #(.VID_W(5), .REF_W(REF_W), .BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .vid(vid),
    .ref_code(ref_code), .busy(busy), .at_target(at_target));

  function automatic int map_code(input logic [4:0] c); // R3
    return (c == 5'b11111) ? 0 : BASE + int'(c);
  endfunction

  task automatic check(input int req, input int er, input bit eb, input bit ea);
    checks++;
    if (ref_code !== REF_W'(er) || busy !== eb || at_target !== ea) begin
      fails++;
      $display("FAIL R%0d: ref=%0d busy=%0b at=%0b expected ref=%0d busy=%0b at=%0b",
               req, ref_code, busy, at_target, er, eb, ea);
    end
  endtask

  task automatic strobe(input logic [4:0] c, input int req);
    exp_t e;
    @(negedge clk);
    vid = c;
    cyc_start = 1'b1;
    if (!m_init) begin
      m_init = 1; m_ref = map_code(c); m_tgt = m_ref; m_acc = c; m_cv = 0; m_ph = 0;
    end else if (m_cv && c == m_cand) begin
      m_tgt = map_code(c); m_acc = c; m_cv = 0; m_ph = 0;
    end else begin
      m_cand = c; m_cv = (c != m_acc);
      if (m_ref != m_tgt) begin
        if (m_ph) m_ref = (m_tgt > m_ref) ? m_ref + 1 : m_ref - 1;
        m_ph = !m_ph;
      end
    end
    @(posedge clk);
    e.r = REF_W'(m_ref); e.b = (m_ref != m_tgt); e.a = (m_ref == m_tgt); e.req = 8'(req);
    q.push_back(e);
    @(negedge clk);
    cyc_start = 1'b0;
    @(negedge clk);
    vid = ~c;            // R4: junk between strobes
    @(negedge clk);
    vid = c;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        check(int'(e.req), int'(e.r), e.b, e.a);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check(1, 0, 0, 0);                         // R1 in reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    vid = 5'd3;
    repeat (3) @(negedge clk);
    check(1, 0, 0, 0);                         // R1 before first strobe
    strobe(5'd10, 2);                          // R2 direct load to 30
    strobe(5'd10, 4);                          // R4 junk between strobes ignored
    strobe(5'd10, 4);
    strobe(5'd12, 5);                          // R5 candidate only
    strobe(5'd12, 5);                          // accepted, target 32
    for (int i = 0; i < 6; i++) strobe(5'd12, 6);  // R6 cadence, R7 upward stop
    strobe(5'd15, 5);                          // candidate 15
    strobe(5'd16, 5);                          // R5 replaced, target unchanged
    strobe(5'd16, 5);                          // accepted, target 36
    strobe(5'd16, 8);
    strobe(5'd16, 8);
    strobe(5'd8, 8);                           // R8 redirect mid-slew
    strobe(5'd8, 8);
    for (int i = 0; i < 14; i++) strobe(5'd8, 7);  // R7 downward to 28
    strobe(5'd31, 3);                          // R3 off code
    strobe(5'd31, 3);
    for (int i = 0; i < 60; i++) strobe(5'd31, 9); // R9 flags during long slew
    strobe(5'd0, 3);                           // back up toward 20
    strobe(5'd0, 3);
    for (int i = 0; i < 6; i++) strobe(5'd0, 7);
    repeat (4) @(negedge clk);
    check(9, m_ref, m_ref != m_tgt, m_ref == m_tgt);  // R9 final idle state
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule